// File: doc/BRIEF.md
# Stipple and Blit Memory Engine

This block is a small drawing accelerator on the write path of a framebuffer. Software drives it with pairs of register writes. The first write of a pair latches a 32-bit colour word. The second write names a target pixel through its register address and carries a command word. The engine then performs the operation on its memory port, one pixel per cycle, and holds `busy` high until it is done.

There are two command windows, selected by `reg_blit`. In the stipple window, the command word is a 32-bit mask. The engine visits 32 consecutive pixels from the target and writes the latched colour wherever the corresponding mask bit is set. In the blit window, the command word holds a run length and a source pixel index. The reserved all-ones source value selects a fill of the run with the latched colour. Any other source value selects a copy from the source run into the target run.

The framebuffer has up to three planes: an 8-bit pixel plane, a 24-bit colour plane used in deep mode, and a 32-bit control plane that only the raw variants update. Copies read with a fixed one-cycle latency, so each read is followed one cycle later by its write.

The sequencer is a five-state machine:
- IDLE accepts writes. On an execute write it moves to STIPPLE (stipple window), FILL (blit window, fill source) or COPY (blit window, any other source).
- STIPPLE returns to IDLE after its 32nd pixel.
- FILL returns to IDLE after the last pixel of its run.
- COPY moves to DRAIN after issuing its last read.
- DRAIN performs the final copy write and returns to IDLE.

Top module: `stipblit_engine`

## Requirements
- R1: A write with register address bit 2 clear stores `reg_wdata` as the colour word. It causes no memory read or write.
- R2: A write with register address bit 2 set starts an operation at target pixel `reg_addr[PIX_W+2:3]`. Address bits 1:0 are not decoded.
- R3: In the stipple window, mask bit 31-i set means pixel target+i receives colour bits 7:0, for i from 0 to 31. Clear bits leave the pixel untouched. `busy` stays high for exactly 32 cycles.
- R4: In the blit window, the run length is command bits 28:24 plus one, giving 1 to 32 pixels. A source field (bits 23:0) of 0xFFFFFF fills target..target+len-1 with colour bits 7:0. `busy` stays high for exactly len cycles.
- R5: Any other source copies pixel source+i to target+i in ascending i. The source index is the low PIX_W bits of the field. One read is issued per cycle, and each write follows its read by one cycle. `busy` stays high for exactly len+1 cycles.
- R6: With `deep_mode` high at the execute write, every pixel write also writes the colour plane. Stipple and fill write colour bits 23:0. A copy copies the colour plane.
- R7: A raw execute (`reg_raw` high) in deep mode also writes the control plane. Stipple writes the full 32-bit colour, fill writes colour bits 23:0 zero-extended, and copy copies the control plane. Outside deep mode, the colour and control planes are never written.
- R8: While `busy` is high, every register write, whether latch or execute, is ignored.
- R9: After reset the engine is idle, with no memory read or write. `busy` is low exactly when no operation is in progress.
- R10: Pixel addresses wrap modulo 2^PIX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_blit | input | 1 | 1 = blit window, 0 = stipple window |
| reg_raw | input | 1 | Raw variant: also update control plane |
| reg_addr | input | PIX_W+3 | Register byte address; bit 2 selects latch or execute |
| reg_wdata | input | 32 | Colour word or command word |
| deep_mode | input | 1 | 24-bit depth configuration |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Read request (data returns next cycle) |
| mem_raddr | output | PIX_W | Read pixel index |
| mem_rdata8 | input | 8 | Pixel plane read data |
| mem_rdata24 | input | 24 | Colour plane read data |
| mem_rdatac | input | 32 | Control plane read data |
| mem_we | output | 1 | Pixel plane write enable |
| mem_we_deep | output | 1 | Colour plane write enable |
| mem_we_ctl | output | 1 | Control plane write enable |
| mem_waddr | output | PIX_W | Write pixel index (all planes) |
| mem_wdata8 | output | 8 | Pixel plane write data |
| mem_wdata24 | output | 24 | Colour plane write data |
| mem_wdatac | output | 32 | Control plane write data |

## Verification
A wrong state or index shows up at the ports within the operation itself. The busy window comes out shorter or longer than 32, len or len+1 cycles. A plane ends up with a pixel written off the run, or one left stale. A copy write appears without its preceding read.

Because the whole framebuffer is compared against an arithmetic model after every operation, each corruption is reported at the end of the command that caused it. This covers a dropped or misordered mask bit, a lost wrap, a wrong plane enable and a colour that was overwritten during busy.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
    localparam int WORD_W   = 32;
    localparam int PIX_BITS = 8;
    localparam int DEEP_W   = 24;
    localparam int SRC_W    = 24;
    localparam int RUN_W    = 5;
    localparam int RUN_LSB  = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STIP,
        ST_FILL,
        ST_COPY,
        ST_DRAIN
    } sbe_state_e;

    typedef enum logic [1:0] {
        OP_STIP,
        OP_FILL,
        OP_COPY
    } sbe_op_e;
endpackage

// File: rtl/sbe_decode.sv
module sbe_decode
    import sbe_pkg::*;
#(
    parameter int PIX_W = 20
) (
    input  logic [PIX_W+2:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              is_blit,
    output logic              is_exec,
    output sbe_op_e           op,
    output logic [PIX_W-1:0]  target,
    output logic [PIX_W-1:0]  src,
    output logic [RUN_W-1:0]  last
);
    logic [SRC_W-1:0] src_field;
    logic             unused_bits;

    assign unused_bits = ^{addr[1:0], wdata[WORD_W-1:RUN_LSB+RUN_W]};
    assign src_field   = wdata[SRC_W-1:0];
    assign is_exec     = addr[2];
    assign target      = addr[PIX_W+2:3];
    assign src         = src_field[PIX_W-1:0];
    assign last        = wdata[RUN_LSB +: RUN_W];

    always_comb begin
        if (!is_blit) begin
            op = OP_STIP;
        end else if (&src_field) begin
            op = OP_FILL;
        end else begin
            op = OP_COPY;
        end
    end
endmodule

// File: rtl/sbe_seq.sv
module sbe_seq
    import sbe_pkg::*;
#(
    parameter int PIX_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              is_exec,
    input  sbe_op_e           op,
    input  logic [PIX_W-1:0]  target,
    input  logic [PIX_W-1:0]  src,
    input  logic [RUN_W-1:0]  last,
    input  logic [WORD_W-1:0] wdata,
    input  logic              raw_in,
    input  logic              deep_in,
    output logic              busy,
    output logic              wr_fire,
    output logic [PIX_W-1:0]  wr_addr,
    output logic              wr_copy,
    output logic              wr_stip,
    output logic              rd_fire,
    output logic [PIX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] colour,
    output logic              deep,
    output logic              raw
);
    localparam logic [RUN_W-1:0] STIP_LAST = '1;

    sbe_state_e        state_q, state_d;
    logic [RUN_W-1:0]  idx_q, last_q;
    logic [PIX_W-1:0]  tgt_q, src_q, cp_addr_q, idx_ext;
    logic [WORD_W-1:0] mask_q, col_q;
    logic              deep_q, raw_q, cp_pend_q;
    logic              accept, at_last;

    assign busy    = (state_q != ST_IDLE);
    assign accept  = wr && !busy;
    assign idx_ext = PIX_W'(idx_q);
    assign at_last = (idx_q == last_q);
    assign colour  = col_q;
    assign deep    = deep_q;
    assign raw     = raw_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_exec) begin
                    unique case (op)
                        OP_STIP: state_d = ST_STIP;
                        OP_FILL: state_d = ST_FILL;
                        default: state_d = ST_COPY;
                    endcase
                end
            end
            ST_STIP:  if (at_last) state_d = ST_IDLE;
            ST_FILL:  if (at_last) state_d = ST_IDLE;
            ST_COPY:  if (at_last) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // operation context and run index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            last_q    <= '0;
            tgt_q     <= '0;
            src_q     <= '0;
            mask_q    <= '0;
            col_q     <= '0;
            deep_q    <= 1'b0;
            raw_q     <= 1'b0;
            cp_pend_q <= 1'b0;
            cp_addr_q <= '0;
        end else begin
            cp_pend_q <= (state_q == ST_COPY);
            cp_addr_q <= tgt_q + idx_ext;
            if (accept && !is_exec) begin
                col_q <= wdata;
            end
            if (accept && is_exec) begin
                idx_q  <= '0;
                last_q <= (op == OP_STIP) ? STIP_LAST : last;
                tgt_q  <= target;
                src_q  <= src;
                mask_q <= wdata;
                deep_q <= deep_in;
                raw_q  <= raw_in;
            end else if (state_q == ST_STIP || state_q == ST_FILL ||
                         state_q == ST_COPY) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // per-state memory commands
    always_comb begin
        wr_fire = 1'b0;
        wr_addr = tgt_q + idx_ext;
        wr_copy = 1'b0;
        wr_stip = 1'b0;
        rd_fire = 1'b0;
        rd_addr = src_q + idx_ext;
        unique case (state_q)
            ST_IDLE: ;
            ST_STIP: begin
                wr_fire = mask_q[STIP_LAST - idx_q];
                wr_stip = 1'b1;
            end
            ST_FILL: wr_fire = 1'b1;
            ST_COPY: begin
                rd_fire = 1'b1;
                wr_fire = cp_pend_q;
                wr_addr = cp_addr_q;
                wr_copy = 1'b1;
            end
            ST_DRAIN: begin
                wr_fire = 1'b1;
                wr_addr = cp_addr_q;
                wr_copy = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sbe_memport.sv
module sbe_memport
    import sbe_pkg::*;
#(
    parameter int PIX_W = 20
) (
    input  logic                wr_fire,
    input  logic [PIX_W-1:0]    wr_addr,
    input  logic                wr_copy,
    input  logic                wr_stip,
    input  logic                rd_fire,
    input  logic [PIX_W-1:0]    rd_addr,
    input  logic [WORD_W-1:0]   colour,
    input  logic                deep,
    input  logic                raw,
    input  logic [PIX_BITS-1:0] rdata8,
    input  logic [DEEP_W-1:0]   rdata24,
    input  logic [WORD_W-1:0]   rdatac,
    output logic                mem_rd,
    output logic [PIX_W-1:0]    mem_raddr,
    output logic                mem_we,
    output logic                mem_we_deep,
    output logic                mem_we_ctl,
    output logic [PIX_W-1:0]    mem_waddr,
    output logic [PIX_BITS-1:0] mem_wdata8,
    output logic [DEEP_W-1:0]   mem_wdata24,
    output logic [WORD_W-1:0]   mem_wdatac
);
    logic [WORD_W-1:0] ctl_colour;

    assign ctl_colour  = wr_stip ? colour : WORD_W'(colour[DEEP_W-1:0]);
    assign mem_rd      = rd_fire;
    assign mem_raddr   = rd_addr;
    assign mem_we      = wr_fire;
    assign mem_we_deep = wr_fire && deep;
    assign mem_we_ctl  = wr_fire && deep && raw;
    assign mem_waddr   = wr_addr;
    assign mem_wdata8  = wr_copy ? rdata8  : colour[PIX_BITS-1:0];
    assign mem_wdata24 = wr_copy ? rdata24 : colour[DEEP_W-1:0];
    assign mem_wdatac  = wr_copy ? rdatac  : ctl_colour;
endmodule

// File: rtl/stipblit_engine.sv
module stipblit_engine
    import sbe_pkg::*;
#(
    parameter int PIX_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_blit,
    input  logic                reg_raw,
    input  logic [PIX_W+2:0]    reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  logic                deep_mode,
    output logic                busy,
    output logic                mem_rd,
    output logic [PIX_W-1:0]    mem_raddr,
    input  logic [PIX_BITS-1:0] mem_rdata8,
    input  logic [DEEP_W-1:0]   mem_rdata24,
    input  logic [WORD_W-1:0]   mem_rdatac,
    output logic                mem_we,
    output logic                mem_we_deep,
    output logic                mem_we_ctl,
    output logic [PIX_W-1:0]    mem_waddr,
    output logic [PIX_BITS-1:0] mem_wdata8,
    output logic [DEEP_W-1:0]   mem_wdata24,
    output logic [WORD_W-1:0]   mem_wdatac
);
    logic              dec_exec;
    sbe_op_e           dec_op;
    logic [PIX_W-1:0]  dec_target, dec_src;
    logic [RUN_W-1:0]  dec_last;
    logic              s_wr_fire, s_wr_copy, s_wr_stip, s_rd_fire;
    logic [PIX_W-1:0]  s_wr_addr, s_rd_addr;
    logic [WORD_W-1:0] s_colour;
    logic              s_deep, s_raw;

    sbe_decode #(.PIX_W(PIX_W)) u_dec (
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .is_blit (reg_blit),
        .is_exec (dec_exec),
        .op      (dec_op),
        .target  (dec_target),
        .src     (dec_src),
        .last    (dec_last)
    );

    sbe_seq #(.PIX_W(PIX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .is_exec (dec_exec),
        .op      (dec_op),
        .target  (dec_target),
        .src     (dec_src),
        .last    (dec_last),
        .wdata   (reg_wdata),
        .raw_in  (reg_raw),
        .deep_in (deep_mode),
        .busy    (busy),
        .wr_fire (s_wr_fire),
        .wr_addr (s_wr_addr),
        .wr_copy (s_wr_copy),
        .wr_stip (s_wr_stip),
        .rd_fire (s_rd_fire),
        .rd_addr (s_rd_addr),
        .colour  (s_colour),
        .deep    (s_deep),
        .raw     (s_raw)
    );

    sbe_memport #(.PIX_W(PIX_W)) u_mem (
        .wr_fire     (s_wr_fire),
        .wr_addr     (s_wr_addr),
        .wr_copy     (s_wr_copy),
        .wr_stip     (s_wr_stip),
        .rd_fire     (s_rd_fire),
        .rd_addr     (s_rd_addr),
        .colour      (s_colour),
        .deep        (s_deep),
        .raw         (s_raw),
        .rdata8      (mem_rdata8),
        .rdata24     (mem_rdata24),
        .rdatac      (mem_rdatac),
        .mem_rd      (mem_rd),
        .mem_raddr   (mem_raddr),
        .mem_we      (mem_we),
        .mem_we_deep (mem_we_deep),
        .mem_we_ctl  (mem_we_ctl),
        .mem_waddr   (mem_waddr),
        .mem_wdata8  (mem_wdata8),
        .mem_wdata24 (mem_wdata24),
        .mem_wdatac  (mem_wdatac)
    );
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
    parameter int PIX_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             deep_mode,
    input logic             busy,
    input logic             mem_rd,
    input logic [PIX_W-1:0] mem_raddr,
    input logic             mem_we,
    input logic             mem_we_deep,
    input logic             mem_we_ctl
);
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd); // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R9
    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr)); // R2
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_we); // R5
    AST_READ_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_raddr == PIX_W'($past(mem_raddr) + 1'b1))); // R5
    AST_DEEP_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_deep |-> mem_we); // R6
    AST_CTL_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_ctl |-> mem_we_deep); // R7
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && !deep_mode) |=> !mem_we_deep || busy); // R8
endmodule

bind stipblit_engine sbe_checker #(.PIX_W(PIX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .deep_mode   (deep_mode),
    .busy        (busy),
    .mem_rd      (mem_rd),
    .mem_raddr   (mem_raddr),
    .mem_we      (mem_we),
    .mem_we_deep (mem_we_deep),
    .mem_we_ctl  (mem_we_ctl)
);

// File: tb/stipblit_engine_tb.sv
module stipblit_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int NPIX = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_blit = 1'b0, reg_raw = 1'b0, deep_mode = 1'b0;
    logic [PW+2:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          busy, mem_rd, mem_we, mem_we_deep, mem_we_ctl;
    logic [PW-1:0] mem_raddr, mem_waddr;
    logic [7:0]    rd8, wd8;
    logic [23:0]   rd24, wd24;
    logic [31:0]   rdc, wdc;

    logic [7:0]  mem8 [NPIX];
    logic [23:0] mem24 [NPIX];
    logic [31:0] memc [NPIX];
    logic [7:0]  exp8 [NPIX];
    logic [23:0] exp24 [NPIX];
    logic [31:0] expc [NPIX];
    int checks = 0, errors = 0, mem_events = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stipblit_engine #(.PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_blit(reg_blit),
        .reg_raw(reg_raw), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .deep_mode(deep_mode), .busy(busy), .mem_rd(mem_rd),
        .mem_raddr(mem_raddr), .mem_rdata8(rd8), .mem_rdata24(rd24),
        .mem_rdatac(rdc), .mem_we(mem_we), .mem_we_deep(mem_we_deep),
        .mem_we_ctl(mem_we_ctl), .mem_waddr(mem_waddr), .mem_wdata8(wd8),
        .mem_wdata24(wd24), .mem_wdatac(wdc)
    );

    function automatic logic [7:0]  p8(int i);  return 8'(i * 37 + 5); endfunction
    function automatic logic [23:0] p24(int i); return 24'(i * 24'h010307 + 24'h400000); endfunction
    function automatic logic [31:0] pc(int i);  return 32'(i * 32'h01000193) ^ 32'h5A5A0000; endfunction

    // framebuffer model, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) begin
                mem8[i] <= p8(i); mem24[i] <= p24(i); memc[i] <= pc(i);
            end
            rd8 <= '0; rd24 <= '0; rdc <= '0;
        end else begin
            if (mem_rd) begin
                rd8 <= mem8[mem_raddr]; rd24 <= mem24[mem_raddr]; rdc <= memc[mem_raddr];
            end
            if (mem_we)      mem8[mem_waddr]  <= wd8;
            if (mem_we_deep) mem24[mem_waddr] <= wd24;
            if (mem_we_ctl)  memc[mem_waddr]  <= wdc;
            if (mem_we || mem_rd) mem_events <= mem_events + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_mem(string req);
        int bad = -1;
        for (int i = 0; i < NPIX; i++)
            if (bad < 0 && (mem8[i] !== exp8[i] || mem24[i] !== exp24[i] || memc[i] !== expc[i]))
                bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: pixel %0d actual %h/%h/%h expected %h/%h/%h", req, bad,
                     mem8[bad], mem24[bad], memc[bad], exp8[bad], exp24[bad], expc[bad]);
        end
    endtask

    task automatic pulse(logic ex, int tgt, logic [31:0] data, logic blit, logic raw);
        @(negedge clk);
        reg_wr = 1'b1; reg_blit = blit; reg_raw = raw;
        reg_addr = {PW'(tgt), ex, 2'b00}; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 200) begin n++; @(negedge clk); end
    endtask

    task automatic do_fill(int tgt, int len, logic [31:0] col, logic deep, logic raw, string req);
        int n;
        deep_mode = deep;
        pulse(1'b0, 0, col, 1'b1, raw);
        pulse(1'b1, tgt, {3'b0, 5'(len - 1), 24'hFFFFFF}, 1'b1, raw);
        wait_idle(n);
        for (int i = 0; i < len; i++) begin
            int a = (tgt + i) % NPIX;
            exp8[a] = col[7:0];
            if (deep) exp24[a] = col[23:0];
            if (deep && raw) expc[a] = {8'h0, col[23:0]};
        end
        chk({req, " busy"}, n, len);
        chk_mem(req);
    endtask

    task automatic do_stip(int tgt, logic [31:0] mask, logic [31:0] col, logic deep, logic raw);
        int n;
        deep_mode = deep;
        pulse(1'b0, 0, col, 1'b0, raw);
        pulse(1'b1, tgt, mask, 1'b0, raw);
        wait_idle(n);
        for (int i = 0; i < 32; i++) begin
            int a = (tgt + i) % NPIX;
            if (mask[31 - i]) begin
                exp8[a] = col[7:0];
                if (deep) exp24[a] = col[23:0];
                if (deep && raw) expc[a] = col;
            end
        end
        chk("R3 stipple busy", n, 32);
        chk_mem("R3/R6/R7/R10 stipple");
    endtask

    task automatic do_copy(int src, int tgt, int len, logic deep, logic raw);
        int n;
        deep_mode = deep;
        // high source bits beyond PW are dropped (R5); field is never all-ones
        pulse(1'b1, tgt, {3'b0, 5'(len - 1), 8'h5C, 8'h00, 8'(src)}, 1'b1, raw);
        wait_idle(n);
        for (int i = 0; i < len; i++) begin
            int s = (src + i) % NPIX;
            int d = (tgt + i) % NPIX;
            exp8[d] = exp8[s];
            if (deep) exp24[d] = exp24[s];
            if (deep && raw) expc[d] = expc[s];
        end
        chk("R5 copy busy", n, len + 1);
        chk_mem("R5/R6/R7/R10 copy");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, ev;
        for (int i = 0; i < NPIX; i++) begin
            exp8[i] = p8(i); exp24[i] = p24(i); expc[i] = pc(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", int'(busy), 0);
        chk("R9 mem_we", int'(mem_we), 0);
        chk("R9 mem_rd", int'(mem_rd), 0);
        chk_mem("R9 memory");

        // R1: latch alone touches nothing
        ev = mem_events;
        pulse(1'b0, 77, 32'hDEADBEEF, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 latch no access", mem_events - ev, 0);
        chk("R1 latch no busy", int'(busy), 0);

        // R4 fill sweep over all lengths, with wrap, depths and raw
        for (int len = 1; len <= 32; len++)
            do_fill((len * 29 + 200) % NPIX, len, 32'hA1000000 | 32'(len * 32'h00030507),
                    len[0], (len % 3) == 0, "R4/R6/R7/R10 fill");

        // R3 stipple patterns, including wrap past the top pixel
        do_stip(10,  32'h80000001, 32'hC0FFEE42, 1'b1, 1'b1);
        do_stip(40,  32'hFFFFFFFF, 32'h12345678, 1'b0, 1'b1);
        do_stip(90,  32'h00000000, 32'h87654321, 1'b1, 1'b1);
        do_stip(240, 32'hA5A53C3C, 32'hFEDCBA98, 1'b1, 1'b0);
        for (int k = 0; k < 32; k += 7)
            do_stip(k * 5 + 120, 32'h1 << k, 32'h0F1E2D00 | 32'(k), 1'b1, 1'b1);

        // R5 copy sweep: lengths 1..32, non-overlapping runs, wrap
        for (int len = 1; len <= 32; len++)
            do_copy((len * 41) % NPIX, (len * 41 + 128) % NPIX, len, len % 3 != 1, len[1]);

        // R8: register writes during busy are ignored
        do_fill(0, 1, 32'h00AA55CC, 1'b1, 1'b0, "R8 setup");
        pulse(1'b1, 10, {3'b0, 5'd31, 24'hFFFFFF}, 1'b1, 1'b0);
        pulse(1'b0, 0, 32'h00777777, 1'b1, 1'b0);
        pulse(1'b1, 100, {3'b0, 5'd3, 24'hFFFFFF}, 1'b1, 1'b0);
        wait_idle(n);
        for (int i = 10; i < 42; i++) begin exp8[i] = 8'hCC; exp24[i] = 24'hAA55CC; end
        chk_mem("R8 execute and latch during busy");
        pulse(1'b1, 200, {3'b0, 5'd0, 24'hFFFFFF}, 1'b1, 1'b0);
        wait_idle(n);
        exp8[200] = 8'hCC; exp24[200] = 24'hAA55CC;
        chk_mem("R8 colour kept");

        // R7: raw in 8-bit mode leaves deep planes alone; R2 different target
        do_fill(150, 8, 32'h99887766, 1'b0, 1'b1, "R2/R7 shallow raw fill");
        do_copy(150, 20, 8, 1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule